// File: doc/BRIEF.md
# Parameter Channel Event and Status Register

This block is one 8-bit register inside the master side of a serial encoder link. It watches the parameter channel that the link engine runs, and it reports the state of that channel to the host through a simple read port. The register holds two kinds of bits. Two event bits latch when something happens: an error in the answer to a long message, or a link-quality value below the warning threshold. These stay set until the host reads them. Three status bits show the current state: whether the channel is still in its initialization handshake, and whether a long or a short message may be started now.

The block also grants message launches. A long or short request from the host is passed on as a one-cycle launch pulse only when the channel is free. From that launch until the remote answer arrives, the channel is held busy. A channel-reset input aborts the pending transaction. A set of protocol-reset sources (a host control bit, an error-count trigger and an external pin) is merged into one registered reset pulse for the link. The same merged reset also clears the register's channel state and all of its events.

The link framing, CRC checks, the computation of the quality value and any host-side timeout are all handled outside this block. They reach it only as plain inputs.

Top module: `pchan_event_reg`

## Requirements
- R1: Read data bits 7, 6 and 3 are always 0. Field positions are: bit 5 initializing, bit 4 long-answer error, bit 2 low quality, bit 1 long free, bit 0 short free.
- R2: While `rst_n` is low at a clock edge, every implemented bit is cleared to 0.
- R3: `rd_data` carries the register only while `rd_en` is high and `rd_addr` equals `REG_ADDR` (default 0x05). Otherwise it reads 0. Such a matching read clears bits 4 and 2 at the clock edge that ends it. A read of any other address leaves those bits unchanged.
- R4: If an event arrives in the same cycle as a clearing read, the read returns the old value and the event bit is still set afterwards.
- R5: Bit 5 equals `init_ack` as sampled at the previous clock edge. A read does not clear it.
- R6: While bit 5 is set, bits 1 and 0 read 0, and neither `long_go` nor `short_go` is raised, whatever the requests.
- R7: A one-cycle pulse on `long_ans_err` sets bit 4. Bit 4 stays set until a matching read, a channel reset or a protocol reset.
- R8: Bit 2 is set at any clock edge where `quality` is below `QUAL_LOW` (default 14), and stays set until a matching read. A value of 14 or 15 does not set it.
- R9: Bits 1 and 0 are always equal. They read 1 when the channel is idle and not initializing. They drop at the edge that accepts a launch and rise again at the edge after `remote_ans` is seen.
- R10: `long_go` equals `long_req` and `short_go` equals `short_req` in the same cycle, but only while the free bits are 1. If both requests are high together, only `long_go` is raised.
- R11: A one-cycle `chan_rst` aborts the pending message and clears bit 4. Bits 1 and 0 then read 0 for one cycle before the channel reads free again.
- R12: Any bit of `prst_req` raises `prst_out` one cycle later. At the same edge, it clears bits 4 and 2 and aborts the channel in the same way as R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 8 | Register contents during a matching read, else 0 |
| init_ack | input | 1 | Level: the remote side acknowledged channel initialization |
| long_ans_err | input | 1 | Pulse: the answer to a long message was erroneous |
| quality | input | QUAL_W | Current link-quality value |
| long_req | input | 1 | Host asks to launch a long message |
| short_req | input | 1 | Host asks to launch a short message |
| remote_ans | input | 1 | Pulse: the remote answer to the pending message arrived |
| long_go | output | 1 | Granted launch of a long message |
| short_go | output | 1 | Granted launch of a short message |
| chan_rst | input | 1 | Parameter-channel reset |
| prst_req | input | PRST_SRC | Protocol-reset sources (control bit, error trigger, external pin) |
| prst_out | output | 1 | Registered protocol-reset pulse to the link |

## Verification
Two functions can land in the same cycle: an event setting a bit, and a host read clearing it. The bench provokes this by raising `long_ans_err`, or by driving `quality` below 14, at the same negative edge that starts a matching read. It then judges the result with two reads. The first read must return the value from before the event. The next read must show the bit set. A third read must show it cleared. A second overlap is handled the same way: a launch request in the same cycle as the initialization flag, or a long request together with a short one, is judged from the grant outputs sampled in that cycle.

// File: rtl/pchan_pkg.sv
// Package for the parameter channel event register.
// Holds the bit positions of the host-visible fields and the event indices
// shared by the top level and the checker.
package pchan_pkg;

    localparam int REG_W    = 8;

    // Field positions in the read word (neighbours decode these).
    localparam int POS_INIT = 5;
    localparam int POS_AERR = 4;
    localparam int POS_QLOW = 2;
    localparam int POS_LFREE = 1;
    localparam int POS_SFREE = 0;

    // Indices of the sticky event bits.
    localparam int EV_AERR  = 0;
    localparam int EV_QLOW  = 1;
    localparam int N_EV     = 2;

    typedef struct packed {
        logic init;
        logic aerr;
        logic qlow;
        logic free;
    } pchan_stat_t;

    // Pack the status fields into the read word; unused bits stay 0.
    function automatic logic [REG_W-1:0] pack_word(input pchan_stat_t s);
        logic [REG_W-1:0] w;
        w = '0;
        w[POS_INIT]  = s.init;
        w[POS_AERR]  = s.aerr;
        w[POS_QLOW]  = s.qlow;
        w[POS_LFREE] = s.free;
        w[POS_SFREE] = s.free;
        return w;
    endfunction

endpackage

// File: rtl/pchan_sticky_bit.sv
// One read-to-clear event bit.
// Assumes: set_i is sampled every edge; a set in the same cycle as a read
// clear wins, so no event is lost; kill_i (block-level abort) beats both.
module pchan_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic kill_i,
    input  logic set_i,
    input  logic rd_clr_i,
    output logic q_o
);

    // Hold, set or clear the event flag.
    always_ff @(posedge clk) begin
        if (!rst_n || kill_i) begin
            q_o <= 1'b0;
        end else begin
            q_o <= set_i | (q_o & ~rd_clr_i);
        end
    end

endmodule

// File: rtl/pchan_chan_ctl.sv
// Parameter channel handshake control.
// Tracks whether a message is pending, registers the initialization level,
// and grants launch requests only while the channel is free.
// Assumes: remote_ans arrives only for a pending message (otherwise ignored);
// a long request beats a simultaneous short request.
module pchan_chan_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic abort_i,
    input  logic init_ack,
    input  logic long_req,
    input  logic short_req,
    input  logic remote_ans,
    output logic init_o,
    output logic free_o,
    output logic long_go,
    output logic short_go
);

    logic busy_q;
    logic busy_n;
    logic free_n;
    logic launch;

    // Grant launches from the registered free flag.
    always_comb begin
        long_go  = long_req & free_o;
        short_go = short_req & free_o & ~long_req;
        launch   = long_go | short_go;
    end

    // Next pending state: abort, launch, answer, hold.
    always_comb begin
        if (abort_i) begin
            busy_n = 1'b0;
        end else if (launch) begin
            busy_n = 1'b1;
        end else if (remote_ans) begin
            busy_n = 1'b0;
        end else begin
            busy_n = busy_q;
        end
        free_n = ~abort_i & ~busy_n & ~init_ack;
    end

    // Register pending, free and initialization state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            free_o <= 1'b0;
            init_o <= 1'b0;
        end else begin
            busy_q <= busy_n;
            free_o <= free_n;
            init_o <= init_ack;
        end
    end

endmodule

// File: rtl/pchan_prst_merge.sv
// Protocol-reset merge.
// ORs the protocol-reset sources into an immediate abort for local state
// and a registered one-cycle-late pulse toward the link.
module pchan_prst_merge #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    output logic             any_o,
    output logic             pulse_o
);

    logic [N_SRC:0] chain;

    assign chain[0] = 1'b0;

    // Build the OR chain across all sources.
    for (genvar i = 0; i < N_SRC; i++) begin : g_or
        assign chain[i+1] = chain[i] | src_i[i];
    end

    assign any_o = chain[N_SRC];

    // Register the merged reset toward the link.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= any_o;
        end
    end

endmodule

// File: rtl/pchan_event_reg.sv
// Parameter channel event and status register (top).
// Collects channel events and status into one host-readable word with
// read-to-clear event bits, grants message launches and merges the
// protocol-reset sources. Assumes one host read port, one cycle per read.
module pchan_event_reg
    import pchan_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h05,
    parameter int                QUAL_W   = 4,
    parameter int                QUAL_LOW = 14,
    parameter int                PRST_SRC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [REG_W-1:0]    rd_data,
    input  logic                init_ack,
    input  logic                long_ans_err,
    input  logic [QUAL_W-1:0]   quality,
    input  logic                long_req,
    input  logic                short_req,
    input  logic                remote_ans,
    output logic                long_go,
    output logic                short_go,
    input  logic                chan_rst,
    input  logic [PRST_SRC-1:0] prst_req,
    output logic                prst_out
);

    localparam logic [QUAL_W-1:0] QLOW_LIM = QUAL_W'(QUAL_LOW);

    logic            rd_hit;
    logic            prst_any;
    logic            qual_low;
    logic            init_q;
    logic            free_q;
    logic [N_EV-1:0] ev_set;
    logic [N_EV-1:0] ev_kill;
    logic [N_EV-1:0] ev_q;
    pchan_stat_t     stat;

    // Decode a read of this register and compare the quality value.
    always_comb begin
        rd_hit   = rd_en && (rd_addr == REG_ADDR);
        qual_low = (quality < QLOW_LIM);
    end

    // Event sources and their abort conditions.
    always_comb begin
        ev_set[EV_AERR]  = long_ans_err;
        ev_set[EV_QLOW]  = qual_low;
        ev_kill[EV_AERR] = chan_rst | prst_any;
        ev_kill[EV_QLOW] = prst_any;
    end

    pchan_prst_merge #(
        .N_SRC (PRST_SRC)
    ) u_prst (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (prst_req),
        .any_o   (prst_any),
        .pulse_o (prst_out)
    );

    for (genvar e = 0; e < N_EV; e++) begin : g_ev
        pchan_sticky_bit u_bit (
            .clk      (clk),
            .rst_n    (rst_n),
            .kill_i   (ev_kill[e]),
            .set_i    (ev_set[e]),
            .rd_clr_i (rd_hit),
            .q_o      (ev_q[e])
        );
    end

    pchan_chan_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_i    (chan_rst | prst_any),
        .init_ack   (init_ack),
        .long_req   (long_req),
        .short_req  (short_req),
        .remote_ans (remote_ans),
        .init_o     (init_q),
        .free_o     (free_q),
        .long_go    (long_go),
        .short_go   (short_go)
    );

    // Assemble the status word and drive it only on a matching read.
    always_comb begin
        stat.init = init_q;
        stat.aerr = ev_q[EV_AERR];
        stat.qlow = ev_q[EV_QLOW];
        stat.free = free_q;
        rd_data   = rd_hit ? pack_word(stat) : '0;
    end

endmodule

// File: rtl/pchan_event_reg_chk.sv
// Checker for pchan_event_reg, bound to every instance of the top.
// Relates ports over time; holds from reset release.
module pchan_event_reg_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h05,
    parameter int                PRST_SRC = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [7:0]          rd_data,
    input logic                init_ack,
    input logic                long_ans_err,
    input logic                long_go,
    input logic                short_go,
    input logic                chan_rst,
    input logic [PRST_SRC-1:0] prst_req,
    input logic                prst_out
);

    logic hit;
    assign hit = rd_en && (rd_addr == REG_ADDR);

    p_unimpl_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] == 1'b0) && (rd_data[6] == 1'b0) && (rd_data[3] == 1'b0));

    p_init_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && $past(rst_n)) |-> (rd_data[5] == $past(init_ack)));

    p_no_grant_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(init_ack)) |-> (!long_go && !short_go));

    p_aerr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (long_ans_err && !chan_rst && !(|prst_req)) |=> (!hit || rd_data[4]));

    p_busy_after_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((long_go || short_go) && !chan_rst && !(|prst_req)) |=> (!long_go && !short_go));

    p_single_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(long_go && short_go));

    p_prst_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|prst_req) |=> prst_out);

endmodule

bind pchan_event_reg pchan_event_reg_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .PRST_SRC (PRST_SRC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .init_ack     (init_ack),
    .long_ans_err (long_ans_err),
    .long_go      (long_go),
    .short_go     (short_go),
    .chan_rst     (chan_rst),
    .prst_req     (prst_req),
    .prst_out     (prst_out)
);

// File: tb/tb_pchan_event_reg.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares.
module tb_pchan_event_reg;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rd_en;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       init_ack;
    logic       long_ans_err;
    logic [3:0] quality;
    logic       long_req;
    logic       short_req;
    logic       remote_ans;
    logic       long_go;
    logic       short_go;
    logic       chan_rst;
    logic [2:0] prst_req;
    logic       prst_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    pchan_event_reg dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .init_ack(init_ack), .long_ans_err(long_ans_err),
        .quality(quality), .long_req(long_req), .short_req(short_req),
        .remote_ans(remote_ans), .long_go(long_go), .short_go(short_go),
        .chan_rst(chan_rst), .prst_req(prst_req), .prst_out(prst_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read against the scoreboard.
    always @(negedge clk) begin
        #2;
        if (rd_en) begin
            if (sb_q.size() == 0) begin
                check("SB-empty", 8'hEE, 8'h00);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, rd_data, it.exp);
            end
        end
    end

    // Driver: one-cycle read; called at a negative edge.
    task automatic do_read(input logic [7:0] addr, input logic [7:0] exp, input string tag);
        rd_en   = 1'b1;
        rd_addr = addr;
        sb_q.push_back('{exp, tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; rd_en = 1'b0; rd_addr = 8'h00; init_ack = 1'b0;
        long_ans_err = 1'b0; quality = 4'd15; long_req = 1'b0; short_req = 1'b0;
        remote_ans = 1'b0; chan_rst = 1'b0; prst_req = '0;
        wait_cyc(3);
        do_read(8'h05, 8'h00, "R2 reset state");
        rst_n = 1'b1;
        wait_cyc(1);
        do_read(8'h05, 8'h03, "R9 idle free");

        // R8 low quality, R3 address gating and clear
        quality = 4'd13; wait_cyc(1); quality = 4'd15;
        do_read(8'h04, 8'h00, "R3 other address");
        do_read(8'h05, 8'h07, "R8 low quality latched");
        do_read(8'h05, 8'h03, "R3 cleared by read");
        quality = 4'd14; wait_cyc(2);
        do_read(8'h05, 8'h03, "R8 boundary 14");
        quality = 4'd15;

        // R7 answer error
        long_ans_err = 1'b1; wait_cyc(1); long_ans_err = 1'b0;
        do_read(8'h04, 8'h00, "R3 other address no clear");
        do_read(8'h05, 8'h13, "R7 answer error latched");
        do_read(8'h05, 8'h03, "R7 cleared by read");

        // R4 event in same cycle as clearing read
        long_ans_err = 1'b1;
        do_read(8'h05, 8'h03, "R4 read sees old value");
        long_ans_err = 1'b0;
        do_read(8'h05, 8'h13, "R4 event kept");
        do_read(8'h05, 8'h03, "R4 cleared after");
        quality = 4'd13;
        do_read(8'h05, 8'h03, "R4 quality old value");
        quality = 4'd15;
        do_read(8'h05, 8'h07, "R4 quality kept");
        do_read(8'h05, 8'h03, "R4 quality cleared");

        // R5 / R6 initialization level
        init_ack = 1'b1; wait_cyc(1);
        do_read(8'h05, 8'h20, "R5 init level");
        long_req = 1'b1; short_req = 1'b1; #2;
        check("R6 long refused", {7'd0, long_go}, 8'h00);
        check("R6 short refused", {7'd0, short_go}, 8'h00);
        @(negedge clk); long_req = 1'b0; short_req = 1'b0;
        do_read(8'h05, 8'h20, "R5 not cleared by read");
        init_ack = 1'b0; wait_cyc(1);
        do_read(8'h05, 8'h03, "R5 init dropped");

        // R9 / R10 launch and answer
        long_req = 1'b1; #2;
        check("R10 long grant", {6'd0, long_go, short_go}, 8'h02);
        @(negedge clk); long_req = 1'b0;
        do_read(8'h05, 8'h00, "R9 busy after long");
        short_req = 1'b1; #2;
        check("R10 short refused busy", {7'd0, short_go}, 8'h00);
        @(negedge clk); short_req = 1'b0;
        remote_ans = 1'b1; wait_cyc(1); remote_ans = 1'b0;
        do_read(8'h05, 8'h03, "R9 free after answer");
        long_req = 1'b1; short_req = 1'b1; #2;
        check("R10 long priority", {6'd0, long_go, short_go}, 8'h02);
        @(negedge clk); long_req = 1'b0; short_req = 1'b0;
        remote_ans = 1'b1; wait_cyc(1); remote_ans = 1'b0;
        short_req = 1'b1; #2;
        check("R10 short grant", {6'd0, long_go, short_go}, 8'h01);
        @(negedge clk); short_req = 1'b0;
        do_read(8'h05, 8'h00, "R9 busy after short");
        remote_ans = 1'b1; wait_cyc(1); remote_ans = 1'b0;
        do_read(8'h05, 8'h03, "R9 free again");

        // R1 all fields together
        quality = 4'd13; long_ans_err = 1'b1; init_ack = 1'b1;
        wait_cyc(1);
        quality = 4'd15; long_ans_err = 1'b0;
        do_read(8'h05, 8'h34, "R1 unused bits zero");
        init_ack = 1'b0; wait_cyc(1);
        do_read(8'h05, 8'h03, "R1 events cleared");

        // R11 channel reset
        long_req = 1'b1; @(negedge clk); long_req = 1'b0;
        long_ans_err = 1'b1; wait_cyc(1); long_ans_err = 1'b0;
        chan_rst = 1'b1; wait_cyc(1); chan_rst = 1'b0;
        do_read(8'h05, 8'h00, "R11 aborted and cleared");
        do_read(8'h05, 8'h03, "R11 free after reset");

        // R12 protocol reset
        quality = 4'd13; long_ans_err = 1'b1; long_req = 1'b1;
        @(negedge clk);
        quality = 4'd15; long_ans_err = 1'b0; long_req = 1'b0;
        prst_req = 3'b100; @(negedge clk); prst_req = '0;
        #1;
        check("R12 reset pulse", {7'd0, prst_out}, 8'h01);
        do_read(8'h05, 8'h00, "R12 all cleared");
        #1;
        check("R12 pulse ends", {7'd0, prst_out}, 8'h00);
        do_read(8'h05, 8'h03, "R12 channel free");
        prst_req = 3'b001; @(negedge clk); prst_req = '0;
        #1;
        check("R12 control source", {7'd0, prst_out}, 8'h01);
        wait_cyc(2);

        if (sb_q.size() != 0) check("SB-leftover", 8'(sb_q.size()), 8'h00);
        finish_run();
    end

endmodule